// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Mixed Page Sizes

This block is a small fully associative translation cache that sits in front of a page-table walker. A requester presents a virtual address, and one clock later the block answers with a hit flag and, on a hit, the translated physical address. Each slot holds a virtual page number, a physical frame number, an address-space tag and a page-size code. The page-size code selects a 4 KiB, 2 MiB or 1 GiB page, which sets how many low address bits pass through untranslated. A current-space register is compared against each slot's tag, so mappings from several address spaces can live side by side.

On a miss the block only reports it. An external walker then writes the mapping through the fill port. The fill lands in the lowest-numbered empty slot, or in the slot under a round-robin pointer when every slot is occupied. Software-style maintenance is available in three forms: drop the slots covering one virtual page, drop every slot at once, or load a new current-space value. Loading a new current-space value removes nothing.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is empty, the current-space register holds 0, `rsp_valid` and `rsp_hit` are 0, and the first lookup misses.
- R2: A lookup presented in cycle N is answered in cycle N+1: `rsp_valid` is 1, and `rsp_hit` is 1 when a valid slot whose tag equals the current-space register covers the address.
- R3: Size codes on `fill_size` are 0 = 4 KiB, 1 = 2 MiB and 2 = 1 GiB. The physical address on a hit is the frame number shifted left by 12, with the low 12, 21 or 30 address bits replaced by the same bits of the virtual address, according to size. Only the virtual page bits above that offset are compared.
- R4: On a miss, or when no lookup was made, `rsp_hit` is 0 and `rsp_paddr` is 0.
- R5: A slot whose tag differs from the current-space register never hits. Writing the register affects lookups from the next cycle onward, and it does not empty any slot, so switching back makes earlier mappings hit again.
- R6: A fill writes the lowest-indexed empty slot. When all slots are full, it writes the slot under a round-robin pointer that starts at 0 after reset and advances by one, wrapping, on each such fill.
- R7: A fill is seen by lookups from the next cycle. A lookup in the same cycle as the fill sees the old contents.
- R8: A single-page invalidate empties every valid slot whose page, at that slot's own size, contains the given virtual page, whatever its tag. Other slots are kept.
- R9: A full flush empties every slot. A lookup in the same cycle misses, and a fill in the same cycle is dropped.
- R10: When several slots match a lookup, the lowest-indexed one supplies the translation.
- R11: A fill and a single-page invalidate in the same cycle both apply. The invalidate acts on the old contents, the new mapping is kept, and the victim is chosen from occupancy before the invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Answer to the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | PA_W | Physical address, zero on a miss |
| fill_en | input | 1 | Write a mapping |
| fill_vpn | input | VA_W-12 | Virtual page number of the mapping |
| fill_pfn | input | PA_W-12 | Frame number of the mapping |
| fill_asid | input | ASID_W | Address-space tag of the mapping |
| fill_size | input | 2 | Page-size code (0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB) |
| inv_en | input | 1 | Single-page invalidate request |
| inv_vpn | input | VA_W-12 | Virtual page to invalidate |
| flush_all | input | 1 | Empty every slot |
| asid_wr_en | input | 1 | Load the current-space register |
| asid_wr_data | input | ASID_W | New current-space value |

## Verification
The hardest state to reach from the ports is a full array in which the round-robin pointer must choose the victim. Closely related is the case where a fill, an invalidate and a lookup collide in one cycle while slots of different sizes overlap the same address. Random stimulus draws every page-number field from a pool of four values per level, so 1 GiB, 2 MiB and 4 KiB mappings overlap often and the eight slots fill up and wrap the pointer many times. Directed sequences then fill the array exactly, overflow it by one, and pair a fill with an invalidate and a flush with a lookup.

// File: rtl/asid_tlb_pkg.sv
`timescale 1ns/1ps
package asid_tlb_pkg;
  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;

  // Untranslated low address bits for a page size.
  function automatic int unsigned ofs_bits(pg_size_e s);
    case (s)
      PG_2M:   return 21;
      PG_1G:   return 30;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/asid_tlb_cmp.sv
`timescale 1ns/1ps
module asid_tlb_cmp
  import asid_tlb_pkg::*;
#(
  parameter int VPN_W  = 27,
  parameter int ASID_W = 8
) (
  input  logic              e_valid,
  input  logic [VPN_W-1:0]  e_vpn,
  input  pg_size_e          e_size,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [VPN_W-1:0]  inv_vpn,
  output logic              lk_match,
  output logic              inv_match
);
  logic [VPN_W-1:0] cmp_mask;

  always_comb begin
    cmp_mask = '1;
    case (e_size)
      PG_2M:   cmp_mask[8:0]  = '0;
      PG_1G:   cmp_mask[17:0] = '0;
      default: ;
    endcase
  end

  assign lk_match  = e_valid && (e_asid == cur_asid) &&
                     (((e_vpn ^ lk_vpn) & cmp_mask) == '0);
  assign inv_match = e_valid && (((e_vpn ^ inv_vpn) & cmp_mask) == '0);
endmodule

// File: rtl/asid_tlb_victim.sv
`timescale 1ns/1ps
module asid_tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_go,
  output logic [IDX_W-1:0]   victim_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign victim_idx = free_found ? free_idx : rr_q;

  always_comb begin
    rr_d = rr_q;
    if (fill_go && !free_found) rr_d = (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go && (valid_vec == '1) |=> rr_q != $past(rr_q)); // R6
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_go |=> $stable(rr_q)); // R6
endmodule

// File: rtl/asid_tlb.sv
`timescale 1ns/1ps
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int VA_W    = 39,
  parameter int PA_W    = 40,
  parameter int ASID_W  = 8,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_paddr,
  input  logic              fill_en,
  input  logic [VA_W-13:0]  fill_vpn,
  input  logic [PA_W-13:0]  fill_pfn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [1:0]        fill_size,
  input  logic              inv_en,
  input  logic [VA_W-13:0]  inv_vpn,
  input  logic              flush_all,
  input  logic              asid_wr_en,
  input  logic [ASID_W-1:0] asid_wr_data
);
  localparam int VPN_W = VA_W - 12;
  localparam int PFN_W = PA_W - 12;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q, valid_d, lk_hit_vec, inv_hit_vec, wr_vec;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  pg_size_e           size_q [ENTRIES];
  logic [ASID_W-1:0]  cur_asid_q, cur_asid_d;
  logic [IDX_W-1:0]   victim_idx, sel_idx;
  logic               sel_found, hit_now, fill_go;
  logic [PA_W-1:0]    pa_now;
  logic [29:0]        ofs_mask;

  // Per-slot comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    asid_tlb_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_cmp (
      .e_valid  (valid_q[g]),
      .e_vpn    (vpn_q[g]),
      .e_size   (size_q[g]),
      .e_asid   (asid_q[g]),
      .cur_asid (cur_asid_q),
      .lk_vpn   (lk_vaddr[VA_W-1:12]),
      .inv_vpn  (inv_vpn),
      .lk_match (lk_hit_vec[g]),
      .inv_match(inv_hit_vec[g])
    );
  end

  assign fill_go = fill_en && !flush_all;

  asid_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_q),
    .fill_go   (fill_go),
    .victim_idx(victim_idx)
  );

  // Next state of occupancy and current space
  always_comb begin
    wr_vec = '0;
    if (fill_go) wr_vec[victim_idx] = 1'b1;
    if (flush_all) valid_d = '0;
    else           valid_d = (valid_q & ~(inv_en ? inv_hit_vec : '0)) | wr_vec;
    cur_asid_d = asid_wr_en ? asid_wr_data : cur_asid_q;
  end

  // Lowest-index hit selection and address assembly
  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_hit_vec[i]) begin
        sel_found = 1'b1;
        sel_idx   = IDX_W'(i);
      end
    end
    hit_now  = lk_valid && sel_found && !flush_all;
    ofs_mask = 30'((64'd1 << ofs_bits(size_q[sel_idx])) - 64'd1);
    pa_now   = {pfn_q[sel_idx], 12'b0};
    pa_now[29:0] = (pa_now[29:0] & ~ofs_mask) | (lk_vaddr[29:0] & ofs_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= '0;
      cur_asid_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_paddr  <= '0;
    end else begin
      valid_q    <= valid_d;
      cur_asid_q <= cur_asid_d;
      rsp_valid  <= lk_valid;
      rsp_hit    <= hit_now;
      rsp_paddr  <= hit_now ? pa_now : '0;
    end
  end

  // Slot payload, written only with a fill enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_vec[i]) begin
        vpn_q[i]  <= fill_vpn;
        pfn_q[i]  <= fill_pfn;
        asid_q[i] <= fill_asid;
        size_q[i] <= pg_size_e'(fill_size);
      end
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R2
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> !rsp_hit || (rsp_paddr[11:0] == $past(lk_vaddr[11:0]))); // R3
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit); // R4
  AST_MISS_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_paddr == '0); // R4
  AST_ASID_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    asid_wr_en && !flush_all && !inv_en && !fill_en |=> valid_q == $past(valid_q)); // R5
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> (valid_q & $past(wr_vec)) != '0); // R6
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en && !fill_en && !flush_all |=> (valid_q & $past(inv_hit_vec)) == '0); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> valid_q == '0); // R9
  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !rsp_hit); // R9
endmodule

// File: tb/sim_asid_tlb.sv
`timescale 1ns/1ps
module sim_asid_tlb;
  localparam int VA_W = 39, PA_W = 40, ASID_W = 8, N = 8;
  localparam int VPN_W = VA_W - 12, PFN_W = PA_W - 12;

  logic clk, rst_n;
  logic lk_valid; logic [VA_W-1:0] lk_vaddr;
  logic rsp_valid, rsp_hit; logic [PA_W-1:0] rsp_paddr;
  logic fill_en; logic [VPN_W-1:0] fill_vpn; logic [PFN_W-1:0] fill_pfn;
  logic [ASID_W-1:0] fill_asid; logic [1:0] fill_size;
  logic inv_en; logic [VPN_W-1:0] inv_vpn; logic flush_all;
  logic asid_wr_en; logic [ASID_W-1:0] asid_wr_data;

  asid_tlb #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_asid(fill_asid), .fill_size(fill_size), .inv_en(inv_en),
    .inv_vpn(inv_vpn), .flush_all(flush_all), .asid_wr_en(asid_wr_en),
    .asid_wr_data(asid_wr_data));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Reference model
  bit                m_v   [N];
  logic [VPN_W-1:0]  m_vpn [N];
  logic [PFN_W-1:0]  m_pfn [N];
  logic [ASID_W-1:0] m_asid[N];
  logic [1:0]        m_sz  [N];
  int                m_rr;
  logic [ASID_W-1:0] m_cur;

  function automatic logic [VPN_W-1:0] vmask(logic [1:0] s);
    logic [VPN_W-1:0] m = '1;
    if (s == 2'd1) m[8:0] = '0;
    if (s == 2'd2) m[17:0] = '0;
    return m;
  endfunction

  function automatic bit covers(int i, logic [VPN_W-1:0] v);
    return m_v[i] && (((m_vpn[i] ^ v) & vmask(m_sz[i])) == '0);
  endfunction

  function automatic logic [PA_W-1:0] make_pa(int i, logic [VA_W-1:0] va);
    logic [PA_W-1:0] pa = {m_pfn[i], 12'b0};
    int k = (m_sz[i] == 2'd1) ? 21 : (m_sz[i] == 2'd2) ? 30 : 12;
    for (int b = 0; b < 30; b++) if (b < k) pa[b] = va[b];
    return pa;
  endfunction

  function automatic logic [VPN_W-1:0] gen_vpn();
    logic [VPN_W-1:0] v;
    v[26:18] = 9'($urandom % 4);
    v[17:9]  = 9'($urandom % 4);
    v[8:0]   = 9'($urandom % 4);
    return v;
  endfunction

  task automatic idle();
    lk_valid = 0; lk_vaddr = '0; fill_en = 0; fill_vpn = '0; fill_pfn = '0;
    fill_asid = '0; fill_size = '0; inv_en = 0; inv_vpn = '0; flush_all = 0;
    asid_wr_en = 0; asid_wr_data = '0;
  endtask

  task automatic look(logic [VPN_W-1:0] v);
    lk_valid = 1; lk_vaddr = {v, 12'($urandom)};
  endtask

  task automatic fill(logic [VPN_W-1:0] v, logic [PFN_W-1:0] p,
                      logic [ASID_W-1:0] a, logic [1:0] s);
    fill_en = 1; fill_vpn = v; fill_pfn = p; fill_asid = a; fill_size = s;
  endtask

  // Predict, advance the model, then compare after the edge.
  task automatic step(string tag);
    bit e_hit = 0; logic [PA_W-1:0] e_pa = '0; bit e_val = lk_valid;
    int vic = -1; bit use_rr = 0;
    if (lk_valid && !flush_all)
      for (int i = 0; i < N; i++)
        if (!e_hit && covers(i, lk_vaddr[VA_W-1:12]) && m_asid[i] == m_cur) begin
          e_hit = 1; e_pa = make_pa(i, lk_vaddr);
        end
    if (flush_all) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
      if (vic < 0) begin vic = m_rr; use_rr = 1; end
      if (inv_en) for (int i = 0; i < N; i++) if (covers(i, inv_vpn)) m_v[i] = 0;
      if (fill_en) begin
        m_v[vic] = 1; m_vpn[vic] = fill_vpn; m_pfn[vic] = fill_pfn;
        m_asid[vic] = fill_asid; m_sz[vic] = fill_size;
        if (use_rr) m_rr = (m_rr + 1) % N;
      end
    end
    if (asid_wr_en) m_cur = asid_wr_data;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== e_val || rsp_hit !== e_hit || rsp_paddr !== e_pa) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b hit=%0b pa=%h, expected valid=%0b hit=%0b pa=%h",
               tag, rsp_valid, rsp_hit, rsp_paddr, e_val, e_hit, e_pa);
    end
    idle();
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [VPN_W-1:0] a, b;
    void'($urandom(32'h5eed));
    idle();
    rst_n = 0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0; m_cur = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: outputs idle after reset, first lookup misses
    n_chk++;
    if (rsp_valid !== 0 || rsp_hit !== 0) begin
      n_bad++;
      $display("FAIL R1: got valid=%0b hit=%0b, expected 0 0", rsp_valid, rsp_hit);
    end
    look(gen_vpn()); step("R1");

    // R3: each page size translates with its own offset width
    for (int s = 0; s < 3; s++) begin
      a = {9'(s + 10), 9'd1, 9'd2};
      fill(a, 28'(32'hABC000 + s), 8'd0, 2'(s)); step("R3");
      look(a ^ 27'h000_0FF); step("R3");
      look(a); step("R3");
    end

    // R6: fill exactly, overflow by one, slot 0 is replaced
    flush_all = 1; step("R9");
    for (int k = 0; k < N; k++) begin fill({9'(k), 18'd0}, 28'(k), 8'd0, 2'd0); step("R6"); end
    fill({9'd100, 18'd0}, 28'd99, 8'd0, 2'd0); step("R6");
    look({9'd0, 18'd0}); step("R6");
    look({9'd1, 18'd0}); step("R6");
    look({9'd100, 18'd0}); step("R6");

    // R7: fill and lookup in one cycle, then again
    flush_all = 1; step("R9");
    a = {9'd7, 9'd7, 9'd7};
    fill(a, 28'h1234, 8'd0, 2'd0); look(a); step("R7");
    look(a); step("R7");

    // R5: tag switch hides then restores a mapping
    asid_wr_en = 1; asid_wr_data = 8'd5; step("R5");
    look(a); step("R5");
    asid_wr_en = 1; asid_wr_data = 8'd0; look(a); step("R5");
    look(a); step("R5");

    // R8: invalidate inside a 2 MiB page, other tag, neighbour kept
    b = {9'd20, 9'd3, 9'd0};
    fill(b, 28'h5000, 8'd9, 2'd1); step("R8");
    asid_wr_en = 1; asid_wr_data = 8'd9; step("R8");
    inv_en = 1; inv_vpn = {9'd20, 9'd3, 9'd77}; step("R8");
    look(b); step("R8");
    asid_wr_en = 1; asid_wr_data = 8'd0; step("R8");
    look(a); step("R8");

    // R10: overlapping 1 GiB and 4 KiB, lowest slot wins
    flush_all = 1; step("R9");
    fill({9'd30, 18'd0}, 28'h40000, 8'd0, 2'd2); step("R10");
    fill({9'd30, 9'd1, 9'd1}, 28'h777, 8'd0, 2'd0); step("R10");
    look({9'd30, 9'd1, 9'd1}); step("R10");

    // R11: fill and invalidate of the same page together
    inv_en = 1; inv_vpn = {9'd30, 9'd2, 9'd2};
    fill({9'd30, 9'd2, 9'd2}, 28'h888, 8'd0, 2'd0); step("R11");
    look({9'd30, 9'd2, 9'd2}); step("R11");

    // R9: flush with lookup and fill in the same cycle
    flush_all = 1; look({9'd30, 9'd2, 9'd2});
    fill({9'd31, 18'd0}, 28'h1, 8'd0, 2'd0); step("R9");
    look({9'd31, 18'd0}); step("R9");
    look({9'd30, 9'd2, 9'd2}); step("R9");

    // Random mix of every operation
    for (int t = 0; t < 4000; t++) begin
      int r = int'($urandom % 100);
      if (r < 55) look(gen_vpn());
      if (($urandom % 100) < 35)
        fill(gen_vpn(), 28'($urandom), 8'($urandom % 3), 2'($urandom % 3));
      if (($urandom % 100) < 6) begin inv_en = 1; inv_vpn = gen_vpn(); end
      if (($urandom % 100) < 2) flush_all = 1;
      if (($urandom % 100) < 5) begin asid_wr_en = 1; asid_wr_data = 8'($urandom % 3); end
      step(lk_valid ? "R2" : "R4");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule